// File: doc/BRIEF.md
# Transmit Word Serializer with Raw Bypass

This block is the last stage of a serial-link transmitter. Once per word period it takes a 40-bit word and sends it to a SERDES over a fast character clock. The output is either two 10-bit characters per fast cycle (pair mode) or one character per fast cycle on the low ten bits (single mode). Normally the word is the output of an upstream 8b/10b encoder, which this block models as a 40-bit input.

In raw mode the encoder and CRC stages are bypassed. A 32-bit data input and an 8-bit side input are joined into the 40-bit word and sent as they are. A test harness uses this to inject coding or CRC errors into the line on purpose.

The block also holds the half-rate word enable and the reset synchroniser for the path. The word rate is a toggling clock enable inside the single fast clock domain, so there is no derived clock. A ready output marks each fast cycle in which the input word is taken. The lane mode and the raw select are sampled only in that cycle, so a word is never split between modes.

Top module: `txs_out_path`

## Requirements
- R1: While rst_ni is low, serdes_o, word_ready_o and word_en_o are all zero, and they go to zero at once when rst_ni falls. After rst_ni rises they stay zero through two more rising edges of clk_i.
- R2: Out of reset, word_en_o is high in the first cycle and then toggles on every rising edge of clk_i, giving half the character rate.
- R3: The block samples the word, the lane mode and the raw select on the rising edge that ends a cycle in which word_ready_o is high. The new word appears on serdes_o from the next cycle.
- R4: In pair mode (ten_bit_i low at the load), serdes_o carries word[39:20] in the first cycle after the load and word[19:0] in the second. word_ready_o is high every second cycle.
- R5: In single mode (ten_bit_i high at the load), serdes_o[9:0] carries word[39:30], word[29:20], word[19:10] and word[9:0] in four successive cycles, and serdes_o[19:10] is zero. word_ready_o is high every fourth cycle.
- R6: With raw_en_i low at the load, the word is enc_word_i, and raw_data_i and raw_ext_i have no effect.
- R7: With raw_en_i high at the load, the word is {raw_ext_i, raw_data_i}, with raw_ext_i in bits [39:32], and enc_word_i has no effect.
- R8: Changes on ten_bit_i, raw_en_i or the word inputs in cycles where word_ready_o is low do not change the word being sent or the mode it is sent in.
- R9: word_ready_o is high only in cycles where word_en_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast character clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| ten_bit_i | input | 1 | Lane mode: 0 for two characters per cycle, 1 for one |
| raw_en_i | input | 1 | Raw bypass select |
| enc_word_i | input | 40 | Encoded word from the upstream encoder |
| raw_data_i | input | 32 | Raw data, bits [31:0] of the raw word |
| raw_ext_i | input | 8 | Raw side input, bits [39:32] of the raw word |
| word_ready_o | output | 1 | High in each cycle in which the input word is taken |
| word_en_o | output | 1 | Half-rate word clock enable |
| serdes_o | output | 20 | Characters to the SERDES; only [9:0] are used in single mode |

## Verification
The assertions assume that the mode inputs and the word inputs hold defined values in every cycle where word_ready_o is high. They also assume that rst_ni is released only while clk_i is stable. The bench drives every input at the falling edge, so it is settled long before the next load edge, and it releases reset at the same point. During a free-running stretch, the bench randomises both mode selects and all word inputs on every cycle. This puts mode changes in every slot of a word, and the per-word sampling rule must keep each word whole.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int CHAR_W_DEF      = 10;
  localparam int LANES_DEF       = 2;
  localparam int WORD_CHARS_DEF  = 4;
  localparam int RAW_W_DEF       = 32;
  localparam int SYNC_STAGES_DEF = 2;

  typedef enum logic {
    MODE_PAIR   = 1'b0,
    MODE_SINGLE = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/txs_rst_sync.sv
module txs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release after STAGES edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/txs_word_en.sv
module txs_word_en (
  input  logic clk_i,
  input  logic rst_ni,
  output logic word_en_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b1;
    else         div_q <= ~div_q;
  end

  assign word_en_o = div_q & rst_ni;

  // R2
  word_en_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (word_en_o != $past(word_en_o)));
endmodule

// File: rtl/txs_word_mux.sv
module txs_word_mux #(
  parameter  int WORD_W = 40,
  parameter  int RAW_W  = 32,
  localparam int EXT_W  = WORD_W - RAW_W
) (
  input  logic              raw_en_i,
  input  logic [WORD_W-1:0] enc_word_i,
  input  logic [RAW_W-1:0]  raw_data_i,
  input  logic [EXT_W-1:0]  raw_ext_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    if (raw_en_i) word_o = {raw_ext_i, raw_data_i};
    else          word_o = enc_word_i;
  end
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer
  import txs_pkg::*;
#(
  parameter  int CHAR_W     = CHAR_W_DEF,
  parameter  int LANES      = LANES_DEF,
  parameter  int WORD_CHARS = WORD_CHARS_DEF,
  localparam int WORD_W     = CHAR_W * WORD_CHARS,
  localparam int OUT_W      = CHAR_W * LANES,
  localparam int WIDE_N     = WORD_W / OUT_W,
  localparam int CNT_W      = (WORD_CHARS > 1) ? $clog2(WORD_CHARS) : 1,
  localparam int WIDE_IW    = (WIDE_N > 1) ? $clog2(WIDE_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_en_i,
  input  logic              ten_bit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic [OUT_W-1:0]  data_o
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WIDE_N - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(WORD_CHARS - 1);

  logic [WORD_W-1:0] hold_q;
  logic [OUT_W-1:0]  out_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  last_slot;
  lane_mode_e        mode_q;
  logic [OUT_W-1:0]  first_c;

  logic [OUT_W-1:0] wide_c   [WIDE_N];
  logic [OUT_W-1:0] narrow_c [WORD_CHARS];

  // chunk views of the held word, most significant first
  for (genvar k = 0; k < WIDE_N; k++) begin : g_wide
    assign wide_c[k] = hold_q[WORD_W-1-k*OUT_W -: OUT_W];
  end
  for (genvar k = 0; k < WORD_CHARS; k++) begin : g_narrow
    assign narrow_c[k] = OUT_W'(hold_q[WORD_W-1-k*CHAR_W -: CHAR_W]);
  end

  assign last_slot = (mode_q == MODE_SINGLE) ? LAST_NARROW : LAST_WIDE;
  assign cnt_nxt   = cnt_q + 1'b1;
  assign ready_o   = rst_ni & (cnt_q == last_slot);
  assign first_c   = ten_bit_i ? OUT_W'(word_i[WORD_W-1 -: CHAR_W])
                               : word_i[WORD_W-1 -: OUT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
      cnt_q  <= LAST_WIDE;
      mode_q <= MODE_PAIR;
    end else if (ready_o) begin
      hold_q <= word_i;
      out_q  <= first_c;
      cnt_q  <= '0;
      mode_q <= lane_mode_e'(ten_bit_i);
    end else begin
      cnt_q  <= cnt_nxt;
      out_q  <= (mode_q == MODE_SINGLE) ? narrow_c[cnt_nxt]
                                        : wide_c[cnt_nxt[WIDE_IW-1:0]];
    end
  end

  assign data_o = out_q;

  // R9
  ready_on_word_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> word_en_i);

  // R3
  load_restarts_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (cnt_q == '0));

  // R8
  word_held_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ($stable(hold_q) && $stable(mode_q)));

  // R5
  single_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SINGLE) |-> (data_o[OUT_W-1:CHAR_W] == '0));

  // R4
  pair_second_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !ten_bit_i) |=> ##1 (data_o == $past(hold_q[OUT_W-1:0])));
endmodule

// File: rtl/txs_out_path.sv
module txs_out_path
  import txs_pkg::*;
#(
  parameter  int CHAR_W      = CHAR_W_DEF,
  parameter  int LANES       = LANES_DEF,
  parameter  int WORD_CHARS  = WORD_CHARS_DEF,
  parameter  int RAW_W       = RAW_W_DEF,
  parameter  int SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int WORD_W      = CHAR_W * WORD_CHARS,
  localparam int EXT_W       = WORD_W - RAW_W,
  localparam int OUT_W       = CHAR_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ten_bit_i,
  input  logic              raw_en_i,
  input  logic [WORD_W-1:0] enc_word_i,
  input  logic [RAW_W-1:0]  raw_data_i,
  input  logic [EXT_W-1:0]  raw_ext_i,
  output logic              word_ready_o,
  output logic              word_en_o,
  output logic [OUT_W-1:0]  serdes_o
);
  logic              path_rst_n;
  logic [WORD_W-1:0] sel_word;

  txs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (path_rst_n)
  );

  txs_word_en u_word_en (
    .clk_i     (clk_i),
    .rst_ni    (path_rst_n),
    .word_en_o (word_en_o)
  );

  txs_word_mux #(.WORD_W(WORD_W), .RAW_W(RAW_W)) u_word_mux (
    .raw_en_i   (raw_en_i),
    .enc_word_i (enc_word_i),
    .raw_data_i (raw_data_i),
    .raw_ext_i  (raw_ext_i),
    .word_o     (sel_word)
  );

  txs_serializer #(
    .CHAR_W     (CHAR_W),
    .LANES      (LANES),
    .WORD_CHARS (WORD_CHARS)
  ) u_serializer (
    .clk_i     (clk_i),
    .rst_ni    (path_rst_n),
    .word_en_i (word_en_o),
    .ten_bit_i (ten_bit_i),
    .word_i    (sel_word),
    .ready_o   (word_ready_o),
    .data_o    (serdes_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !path_rst_n |-> (!word_ready_o && !word_en_o && serdes_o == '0));
endmodule

// File: tb/txs_out_path_tb_top.sv
module txs_out_path_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ten_bit_i = 1'b0;
  logic        raw_en_i = 1'b0;
  logic [39:0] enc_word_i = '0;
  logic [31:0] raw_data_i = '0;
  logic [7:0]  raw_ext_i = '0;
  logic        word_ready_o;
  logic        word_en_o;
  logic [19:0] serdes_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  txs_out_path dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ten_bit_i    (ten_bit_i),
    .raw_en_i     (raw_en_i),
    .enc_word_i   (enc_word_i),
    .raw_data_i   (raw_data_i),
    .raw_ext_i    (raw_ext_i),
    .word_ready_o (word_ready_o),
    .word_en_o    (word_en_o),
    .serdes_o     (serdes_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  logic [19:0] exp_out  = '0;
  logic        exp_rdy  = 1'b0;
  logic        exp_wen  = 1'b0;
  string       out_tag  = "R1";
  int          rel      = -1;
  logic [19:0] chunk_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(int mode);
    enc_word_i = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
    raw_data_i = $urandom;
    raw_ext_i  = 8'($urandom);
    case (mode)
      0: begin ten_bit_i = 1'b0; raw_en_i = 1'b0; end
      1: begin ten_bit_i = 1'b0; raw_en_i = 1'b1; end
      2: begin ten_bit_i = 1'b1; raw_en_i = 1'b0; end
      3: begin ten_bit_i = 1'b1; raw_en_i = 1'b1; end
      default: begin ten_bit_i = 1'($urandom); raw_en_i = 1'($urandom); end
    endcase
  endtask

  task automatic model_step(int mode);
    logic [39:0] w;
    string t;
    if (rel < 0) begin
      exp_out = '0; exp_rdy = 1'b0; exp_wen = 1'b0; out_tag = "R1";
      return;
    end
    if (rel == 0) begin
      rel = 1;
      exp_out = '0; exp_rdy = 1'b1; exp_wen = 1'b1; out_tag = "R1";
      return;
    end
    if (exp_rdy) begin
      w = raw_en_i ? {raw_ext_i, raw_data_i} : enc_word_i;
      t = $sformatf("%s %s%s", ten_bit_i ? "R5" : "R4", raw_en_i ? "R7" : "R6",
                    (mode == 4) ? " R8" : "");
      if (ten_bit_i) begin
        for (int k = 0; k < 4; k++) begin
          chunk_q.push_back({10'b0, w[39-10*k -: 10]});
          tag_q.push_back(t);
        end
      end else begin
        for (int k = 0; k < 2; k++) begin
          chunk_q.push_back(w[39-20*k -: 20]);
          tag_q.push_back(t);
        end
      end
    end
    exp_wen = ~exp_wen;
    exp_out = chunk_q.pop_front();
    out_tag = tag_q.pop_front();
    exp_rdy = (chunk_q.size() == 0);
  endtask

  task automatic step(int mode);
    @(negedge clk);
    chk(out_tag, 40'(serdes_o), 40'(exp_out));
    chk(exp_rdy ? "R3 R4 R5" : "R3", 40'(word_ready_o), 40'(exp_rdy));
    chk("R2 R9", 40'(word_en_o), 40'(exp_wen));
    drive(mode);
    model_step(mode);
  endtask

  task automatic release_reset();
    @(negedge clk);
    chk("R1", 40'(serdes_o), 40'(exp_out));
    chk("R1", 40'(word_ready_o), 40'(exp_rdy));
    chk("R1", 40'(word_en_o), 40'(exp_wen));
    rst_ni = 1'b1;
    rel = 0;
    exp_out = '0; exp_rdy = 1'b0; exp_wen = 1'b0; out_tag = "R1";
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    for (int i = 0; i < 3; i++) step(4);
    release_reset();
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 120; i++) step(m);
    for (int i = 0; i < 400; i++) step(4);
    // mid-run asynchronous reset
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", 40'(serdes_o), 40'h0);
    chk("R1", 40'(word_ready_o), 40'h0);
    chk("R1", 40'(word_en_o), 40'h0);
    rel = -1;
    chunk_q.delete();
    tag_q.delete();
    exp_out = '0; exp_rdy = 1'b0; exp_wen = 1'b0; out_tag = "R1";
    for (int i = 0; i < 4; i++) step(4);
    release_reset();
    for (int i = 0; i < 60; i++) step(2);
    for (int i = 0; i < 200; i++) step(4);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule